// File: doc/BRIEF.md
# Single-Step Clock Controller

This block produces the clock for a small hobby processor from a slow, free-running input clock. It has two operating modes. In automatic mode the slow clock passes straight through to the output. In manual mode a push button generates single clock pulses, one per press. A halt input forces the output low whenever it is asserted.

A two-terminal toggle switch selects the mode. Its two active-low terminals feed a set-priority latch that records the last side the switch touched. While the switch is travelling or bouncing, neither terminal is asserted and the latch holds its value. Two indicator outputs show the selected mode and are always complementary. A constant-low output acts as a return line for the indicator LEDs.

In manual mode a press sets a push latch right away. A hold flag samples the push latch on every rising edge of the slow clock. The hold flag clears the push latch once the button is released. The output stays high while either the push latch or the hold flag is set, so every press lasts until a full slow-clock period has passed after release. The whole block runs on a fast system clock. The slow clock, the button and the switch terminals each pass through a two-flop synchronizer.

Top module: `step_clock_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, manual mode is selected (ind_man_o=1, ind_auto_o=0), and the push latch and hold flag are cleared, so clk_o=0.
- R2: The mode latch follows next = auto_side OR (NOT man_side AND current). A side is asserted when its pin is 0. If both pins are 0, automatic mode is selected. If both pins are 1, the latch holds its value.
- R3: ind_auto_o is 1 in automatic mode. ind_man_o is always its complement.
- R4: Bounce between one switch side and the released position (both pins 1) never changes the selected mode.
- R5: In automatic mode with halt_i=0, clk_o equals slow_clk_i delayed by two system-clock cycles.
- R6: In manual mode, a press shorter than one slow period keeps clk_o high for at least SLOW_PER and at most 2*SLOW_PER+1 system cycles, where SLOW_PER is the slow period in system cycles.
- R7: In manual mode, a press of L system cycles keeps clk_o high for at least L and at most L+SLOW_PER+2 system cycles.
- R8: A button press in automatic mode has no effect. After switching to manual mode with the button released, clk_o stays 0.
- R9: halt_i (active-high) forces clk_o and clk_led_o to 0 in the same cycle. When halt is released, the output returns to its gated value.
- R10: clk_led_o always equals clk_o, and led_ret_o is always 0.
- R11: A mode change shows on the indicators on the third system-clock edge after the switch pins change. A press drives clk_o high on the third edge after button_i rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Synchronous reset, active-low |
| slow_clk_i | input | 1 | Free-running slow clock, asynchronous |
| button_i | input | 1 | Single-step push button, active-high |
| sel_auto_n_i | input | 1 | Switch terminal for automatic mode, active-low |
| sel_man_n_i | input | 1 | Switch terminal for manual mode, active-low |
| halt_i | input | 1 | Halt, active-high, gates the output directly |
| clk_o | output | 1 | Generated clock |
| clk_led_o | output | 1 | Copy of clk_o for an LED |
| ind_auto_o | output | 1 | Automatic-mode indicator |
| ind_man_o | output | 1 | Manual-mode indicator |
| led_ret_o | output | 1 | Constant low return for the indicators |

## Verification
Inputs change on the falling edge and outputs are sampled 5 ns after a rising edge. This gives each latency a fixed count of edges.

- Switch changes are checked as still old after the second edge and as new after the third.
- Pass-through is compared against the slow level seen at the previous sample, which reflects the two synchronizer stages.
- Halt is checked 1 ns after it is driven, with no edge in between.
- Pulse widths are measured as counts of high samples. Because slow-clock edges land at an unknown phase, these counts are checked against the bounds in R6 and R7 rather than exact values.

// File: rtl/scc_pkg.sv
// Shared definitions for the single-step clock controller.
// Assumes: nothing beyond IEEE 1800-2017.
package scc_pkg;
    // Default number of synchronizer flops on each asynchronous input
    localparam int unsigned SYNC_STAGES_DEF = 2;

    // Selected operating mode as held by the mode latch
    typedef enum logic {
        MODE_MANUAL = 1'b0,
        MODE_AUTO   = 1'b1
    } run_mode_e;
endpackage

// File: rtl/scc_sync.sv
// Multi-flop synchronizer for a vector of independent asynchronous bits.
// Assumes: each bit is a slow level; no bus coherency is required.
module scc_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // First stage captures the raw input
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d;
    end

    genvar i;
    generate
        for (i = 1; i < STAGES; i++) begin : g_stage
            // Each further stage resolves metastability from the previous one
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= RST_VAL;
                else        stg[i] <= stg[i-1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/scc_mode_latch.sv
// Set-priority latch that debounces the two-terminal mode switch.
// Assumes: request inputs are synchronized and active-high.
module scc_mode_latch
    import scc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      auto_req,
    input  logic      man_req,
    output run_mode_e mode
);
    run_mode_e mode_q;

    // Set on automatic side, clear on manual side, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n)        mode_q <= MODE_MANUAL;
        else if (auto_req) mode_q <= MODE_AUTO;
        else if (man_req)  mode_q <= MODE_MANUAL;
    end

    assign mode = mode_q;

    // R2
    auto_side_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        auto_req |=> mode == MODE_AUTO);
    // R2
    man_side_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (man_req && !auto_req) |=> mode == MODE_MANUAL);
    // R4
    travel_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!man_req && !auto_req) |=> $stable(mode));
endmodule

// File: rtl/scc_step_pulse.sv
// Stretches a button press into a pulse lasting one full slow cycle after release.
// Assumes: btn synchronized; slow_rise is a one-cycle strobe per slow rising edge.
module scc_step_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic btn,
    input  logic manual,
    input  logic slow_rise,
    output logic push_q,
    output logic hold_q
);
    logic push_set;
    assign push_set = btn & manual;

    // Push latch: set has priority over the hold-driven clear
    always_ff @(posedge clk) begin
        if (!rst_n) push_q <= 1'b0;
        else        push_q <= push_set | (push_q & ~hold_q);
    end

    // Hold flag samples the push latch on each slow rising edge
    always_ff @(posedge clk) begin
        if (!rst_n)         hold_q <= 1'b0;
        else if (slow_rise) hold_q <= push_q;
    end

    // R6
    push_set_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (btn && manual) |=> push_q);
    // R7
    hold_only_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !slow_rise |=> $stable(hold_q));
    // R7
    hold_tracks_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slow_rise |=> hold_q == $past(push_q));
endmodule

// File: rtl/step_clock_ctrl.sv
// Top: single-step clock controller with auto pass-through and halt gating.
// Assumes: halt_i is already synchronous to clk; other inputs are asynchronous.
module step_clock_ctrl
    import scc_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_clk_i,
    input  logic button_i,
    input  logic sel_auto_n_i,
    input  logic sel_man_n_i,
    input  logic halt_i,
    output logic clk_o,
    output logic clk_led_o,
    output logic ind_auto_o,
    output logic ind_man_o,
    output logic led_ret_o
);
    localparam int unsigned NIN = 4;
    localparam logic [NIN-1:0] IN_RST = 4'b0011;

    logic [NIN-1:0] raw_in, sync_in;
    logic slow_s, btn_s, auto_req, man_req;
    logic slow_prev, slow_rise;
    logic push_q, hold_q, gated;
    run_mode_e mode;

    assign raw_in = {slow_clk_i, button_i, sel_auto_n_i, sel_man_n_i};

    scc_sync #(.W(NIN), .STAGES(SYNC_STAGES), .RST_VAL(IN_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_in)
    );

    assign slow_s   = sync_in[3];
    assign btn_s    = sync_in[2];
    assign auto_req = ~sync_in[1];
    assign man_req  = ~sync_in[0];

    // Remember last synchronized slow level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) slow_prev <= 1'b0;
        else        slow_prev <= slow_s;
    end
    assign slow_rise = slow_s & ~slow_prev;

    scc_mode_latch u_mode (
        .clk(clk), .rst_n(rst_n), .auto_req(auto_req), .man_req(man_req), .mode(mode)
    );

    scc_step_pulse u_step (
        .clk(clk), .rst_n(rst_n), .btn(btn_s), .manual(mode == MODE_MANUAL),
        .slow_rise(slow_rise), .push_q(push_q), .hold_q(hold_q)
    );

    // Select the clock source for the current mode, then apply halt
    always_comb begin
        if (mode == MODE_AUTO) gated = slow_s;
        else                   gated = push_q | hold_q;
        clk_o = gated & ~halt_i;
    end

    assign clk_led_o  = clk_o;
    assign ind_auto_o = (mode == MODE_AUTO);
    assign ind_man_o  = (mode == MODE_MANUAL);
    assign led_ret_o  = 1'b0;

    // R9
    halt_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_i |-> !clk_o);
    // R3
    one_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ind_auto_o != ind_man_o);
    // R8
    auto_no_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_AUTO && !push_q) |=> !push_q);
endmodule

// File: tb/step_clock_ctrl_tb_top.sv
module step_clock_ctrl_tb_top;
    localparam int SLOW_HALF = 8;
    localparam int SLOW_PER  = 2 * SLOW_HALF;

    logic clk = 0, rst_n = 0;
    logic slow_clk_i = 0, button_i = 0, sel_auto_n_i = 1, sel_man_n_i = 1, halt_i = 0;
    logic clk_o, clk_led_o, ind_auto_o, ind_man_o, led_ret_o;
    int n_chk = 0, n_bad = 0;

    step_clock_ctrl dut_i (.*);

    always #10 clk = ~clk;

    // Slow clock toggles on falling edges every SLOW_HALF cycles
    int sc = 0;
    always @(negedge clk) begin
        if (sc == SLOW_HALF - 1) begin sc <= 0; slow_clk_i <= ~slow_clk_i; end
        else sc <= sc + 1;
    end

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic smp; @(posedge clk); #5; endtask

    // {sel_auto_n, sel_man_n, expected auto}
    localparam logic [2:0] VEC [8] = '{
        3'b10_0, 3'b11_0, 3'b01_1, 3'b11_1, 3'b00_1, 3'b10_0, 3'b11_0, 3'b01_1
    };

    initial begin
        #4000000;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic prev_exp;
        logic prev_slow;
        int hi;
        repeat (4) smp();
        // R1 reset state
        chk("R1 ind_man", ind_man_o, 1'b1);
        chk("R1 ind_auto", ind_auto_o, 1'b0);
        chk("R1 clk_o", clk_o, 1'b0);
        #5 rst_n = 1;
        repeat (3) smp();
        prev_exp = 1'b0;

        // Vector walk: R2, R3, R10, R11 latency
        foreach (VEC[i]) begin
            @(negedge clk);
            sel_auto_n_i = VEC[i][2]; sel_man_n_i = VEC[i][1];
            smp(); smp();
            chk("R11 old mode after 2 edges", ind_auto_o, prev_exp);
            smp();
            chk("R2 mode latch", ind_auto_o, VEC[i][0]);
            chk("R3 complement", ind_man_o, ~VEC[i][0]);
            chk("R10 led copy", clk_led_o, clk_o);
            chk("R10 return low", led_ret_o, 1'b0);
            prev_exp = VEC[i][0];
        end

        // R5 pass-through in auto mode (currently auto)
        smp(); prev_slow = slow_clk_i;
        for (int k = 0; k < 3 * SLOW_PER; k++) begin
            smp();
            chk("R5 pass-through", clk_o, prev_slow);
            chk("R10 led copy", clk_led_o, clk_o);
            prev_slow = slow_clk_i;
        end

        // R9 halt gates output same cycle
        wait (slow_clk_i == 1); repeat (3) smp();
        #5 halt_i = 1; #1;
        chk("R9 halt low", clk_o, 1'b0);
        chk("R9 halt led low", clk_led_o, 1'b0);
        smp(); smp();
        @(negedge clk); halt_i = 0;
        smp(); prev_slow = slow_clk_i; smp();
        chk("R9 release follows slow", clk_o, prev_slow);

        // R8 button in auto ignored
        @(negedge clk); button_i = 1;
        repeat (6) smp();
        @(negedge clk); button_i = 0;
        repeat (4) smp();
        @(negedge clk); sel_auto_n_i = 1; sel_man_n_i = 0;
        repeat (4) smp();
        @(negedge clk); sel_man_n_i = 1;
        for (int k = 0; k < SLOW_PER; k++) begin
            smp(); chk("R8 no pulse after auto press", clk_o, 1'b0);
        end

        // R4 bounce on manual side and on auto side
        for (int k = 0; k < 20; k++) begin
            @(negedge clk); sel_man_n_i = (k % 3 == 0);
            #6; chk("R4 bounce manual", ind_man_o, 1'b1);
        end
        @(negedge clk); sel_man_n_i = 1;

        // R11 press latency then R6 short press
        @(negedge clk); button_i = 1;
        smp(); smp();
        chk("R11 no output after 2 edges", clk_o, 1'b0);
        smp(); hi = 1;
        chk("R11 output high after 3 edges", clk_o, 1'b1);
        #5 button_i = 0;
        for (int k = 0; k < 3 * SLOW_PER; k++) begin smp(); if (clk_o) hi++; end
        n_chk++;
        if (hi < SLOW_PER || hi > 2 * SLOW_PER + 1) begin
            n_bad++;
            $display("FAIL R6 short width actual=%0d expected=%0d..%0d", hi, SLOW_PER, 2*SLOW_PER+1);
        end

        // R7 long press of 50 cycles
        hi = 0;
        for (int k = 0; k < 50 + 3 * SLOW_PER; k++) begin
            smp(); if (clk_o) hi++;
            #5 button_i = (k < 50);
        end
        n_chk++;
        if (hi < 50 || hi > 50 + SLOW_PER + 2) begin
            n_bad++;
            $display("FAIL R7 long width actual=%0d expected=%0d..%0d", hi, 50, 50+SLOW_PER+2);
        end

        // R9 halt inside a manual pulse
        @(negedge clk); button_i = 1;
        repeat (4) smp();
        #5 halt_i = 1; #1;
        chk("R9 halt manual", clk_o, 1'b0);
        #4 halt_i = 0; #1;
        chk("R9 release manual", clk_o, 1'b1);
        button_i = 0;

        // R1 reset mid-pulse
        @(negedge clk); rst_n = 0;
        smp();
        chk("R1 reset clears pulse", clk_o, 1'b0);
        chk("R1 reset manual", ind_man_o, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule